// File: doc/BRIEF.md
# Nth-Chance Clock Victim Selector

This block picks a frame slot to evict when a page fault needs a free frame. It keeps a ring of `NUM_SLOTS` slots. Each slot has a referenced flag, a modified (dirty) flag and a small sweep counter. A pointer called the hand stays where it stopped at the end of the last search. When a fault request arrives, the hand walks the ring one slot per clock. A referenced slot loses its flag, its counter is zeroed and the hand moves on. An unreferenced slot counts one more sweep. It is taken as the victim once that count reaches its threshold: `CLEAN_N` for clean slots and the larger `DIRTY_N` for dirty ones. With a threshold of 1 a clean slot is treated exactly as in second-chance clock.

Memory-access logic pulses the reference strobe and the dirty strobe, each with a slot index, whenever a frame is touched or written. The fault handler raises a one-cycle request while the block is idle. It then waits for the one-cycle victim pulse, which carries the slot index and a write-back flag. The victim slot is left clean, unreferenced and with a zero count, ready to be refilled.

Control is a three-state machine:
- `ST_IDLE` waits. A request moves it to `ST_SCAN`.
- `ST_SCAN` examines the slot under the hand in each cycle. It stays in `ST_SCAN` while the slot is skipped and goes to `ST_DONE` when the slot is chosen.
- `ST_DONE` presents the result for one cycle and always returns to `ST_IDLE`.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset, `busy_o` and `victim_valid_o` are 0, every slot is clean, unreferenced and has a zero count, and the hand is on slot 0, so the first request returns slot 0.
- R2: A request on `fault_req_i` is taken only in `ST_IDLE`. `busy_o` is 1 from the cycle after acceptance through the result cycle. A request made while busy is dropped and starts no second search.
- R3: The hand examines exactly one slot per clock in ascending order and wraps from `NUM_SLOTS-1` to 0. The victim pulse appears 2 + k clocks after the request edge, where k is the number of slots skipped.
- R4: A slot whose referenced flag is set when the hand examines it has the flag cleared and its sweep count reset to 0, and it is skipped.
- R5: An unreferenced clean slot is chosen when its count plus one reaches `CLEAN_N`. Below that it is skipped and its count increments. With `CLEAN_N` = 1 such a slot is chosen on the first visit.
- R6: An unreferenced dirty slot uses `DIRTY_N` in place of `CLEAN_N`, so with defaults it survives one visit and is chosen on the next. `victim_dirty_o` is 1 exactly when the chosen slot was dirty.
- R7: After a victim is reported, the hand rests on the slot following the victim, wrapping after the last slot, and the next search starts there.
- R8: The chosen slot has its referenced flag, dirty flag and count cleared, so a later visit treats it as a clean, unreferenced slot.
- R9: Reference and dirty strobes set their slot's flag at the clock edge where they are sampled, including during a search. A strobe on a slot the hand has not yet reached changes that slot's outcome in the same search.
- R10: `victim_valid_o` is a single-cycle pulse. `victim_idx_o` and `victim_dirty_o` are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_set_i | input | 1 | Set the referenced flag of slot `ref_idx_i` |
| ref_idx_i | input | IDX_W | Slot index for the reference strobe |
| dirty_set_i | input | 1 | Set the dirty flag of slot `dirty_idx_i` |
| dirty_idx_i | input | IDX_W | Slot index for the dirty strobe |
| fault_req_i | input | 1 | One-cycle request for a victim |
| busy_o | output | 1 | A search or result is in progress |
| victim_valid_o | output | 1 | One-cycle result pulse |
| victim_idx_o | output | IDX_W | Chosen slot index |
| victim_dirty_o | output | 1 | Chosen slot needs write-back |

## Verification
Each kind of internal fault shows up at the ports within one search:
- A wrong hand position or skipped step shows up as a wrong victim index or a wrong latency on the very next request.
- A sweep count that is not zeroed or not incremented moves the victim to a different slot one search later.
- A referenced flag that is not cleared makes the next pass skip a slot it should have taken.
- A stale dirty flag on a refilled slot shows up as a spurious write-back flag when the hand next reaches that slot.

The directed sequence is chained so that every slot state built up in one scenario is read back through a victim choice in a later one.

// File: rtl/clock_repl_pkg.sv
package clock_repl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } hand_state_e;

endpackage

// File: rtl/clock_slot_array.sv
module clock_slot_array #(
    parameter int NUM_SLOTS = 8,
    parameter int CLEAN_N   = 1,
    parameter int DIRTY_N   = 2,
    parameter int IDX_W     = $clog2(NUM_SLOTS),
    parameter int CNT_W     = $clog2(DIRTY_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_set_i,
    input  logic [IDX_W-1:0] ref_idx_i,
    input  logic             dirty_set_i,
    input  logic [IDX_W-1:0] dirty_idx_i,
    input  logic             exam_en_i,
    input  logic [IDX_W-1:0] exam_idx_i,
    output logic             exam_victim_o,
    output logic             exam_dirty_o
);

    localparam logic [CNT_W:0] CLEAN_THR = (CNT_W+1)'(CLEAN_N);
    localparam logic [CNT_W:0] DIRTY_THR = (CNT_W+1)'(DIRTY_N);

    logic [NUM_SLOTS-1:0] ref_q;
    logic [NUM_SLOTS-1:0] dirty_q;
    logic [NUM_SLOTS-1:0] ready_w;
    logic [CNT_W-1:0]     cnt_q [NUM_SLOTS];

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic [CNT_W:0] sweeps_w;
        logic           here_w;

        assign sweeps_w   = {1'b0, cnt_q[i]} + 1'b1;
        assign here_w     = exam_en_i && (exam_idx_i == IDX_W'(i));
        assign ready_w[i] = !ref_q[i] &&
                            (sweeps_w >= (dirty_q[i] ? DIRTY_THR : CLEAN_THR));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ref_q[i]   <= 1'b0;
                dirty_q[i] <= 1'b0;
                cnt_q[i]   <= '0;
            end else begin
                if (here_w) begin
                    if (ref_q[i]) begin
                        ref_q[i] <= 1'b0;
                        cnt_q[i] <= '0;
                    end else if (ready_w[i]) begin
                        dirty_q[i] <= 1'b0;
                        cnt_q[i]   <= '0;
                    end else begin
                        cnt_q[i] <= sweeps_w[CNT_W-1:0];
                    end
                end
                if (ref_set_i && ref_idx_i == IDX_W'(i)) begin
                    ref_q[i] <= 1'b1;
                end
                if (dirty_set_i && dirty_idx_i == IDX_W'(i)) begin
                    dirty_q[i] <= 1'b1;
                end
            end
        end
    end

    assign exam_victim_o = exam_en_i && ready_w[exam_idx_i];
    assign exam_dirty_o  = dirty_q[exam_idx_i];

    // R4: a referenced slot under the hand loses its flag and its count
    a_r4_ref_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (exam_en_i && ref_q[exam_idx_i] && !(ref_set_i && ref_idx_i == exam_idx_i))
        |=> (!ref_q[$past(exam_idx_i)] && cnt_q[$past(exam_idx_i)] == '0));

    // R8: a chosen slot is left clean with a zero count
    a_r8_victim_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (exam_victim_o && !(dirty_set_i && dirty_idx_i == exam_idx_i))
        |=> (!dirty_q[$past(exam_idx_i)] && cnt_q[$past(exam_idx_i)] == '0));

    // R6: a dirty slot is never chosen before its count reaches the dirty threshold
    a_r6_dirty_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        (exam_victim_o && exam_dirty_o)
        |-> ({1'b0, cnt_q[exam_idx_i]} + 1'b1 >= DIRTY_THR));

endmodule

// File: rtl/clock_hand_fsm.sv
module clock_hand_fsm
    import clock_repl_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_req_i,
    input  logic             exam_victim_i,
    input  logic             exam_dirty_i,
    output logic             exam_en_o,
    output logic [IDX_W-1:0] hand_o,
    output logic             busy_o,
    output logic             victim_valid_o,
    output logic [IDX_W-1:0] victim_idx_o,
    output logic             victim_dirty_o
);

    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_SLOTS - 1);

    hand_state_e      state_q, state_d;
    logic [IDX_W-1:0] hand_q;
    logic [IDX_W-1:0] vic_idx_q;
    logic             vic_dirty_q;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] idx);
        return (idx == LAST_SLOT) ? '0 : idx + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fault_req_i)   state_d = ST_SCAN;
            ST_SCAN: if (exam_victim_i) state_d = ST_DONE;
            ST_DONE:                    state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hand_q      <= '0;
            vic_idx_q   <= '0;
            vic_dirty_q <= 1'b0;
        end else if (state_q == ST_SCAN) begin
            hand_q <= step(hand_q);
            if (exam_victim_i) begin
                vic_idx_q   <= hand_q;
                vic_dirty_q <= exam_dirty_i;
            end
        end
    end

    always_comb begin
        exam_en_o      = 1'b0;
        busy_o         = 1'b0;
        victim_valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SCAN: begin
                exam_en_o = 1'b1;
                busy_o    = 1'b1;
            end
            ST_DONE: begin
                busy_o         = 1'b1;
                victim_valid_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign hand_o         = hand_q;
    assign victim_idx_o   = vic_idx_q;
    assign victim_dirty_o = vic_dirty_q;

    // R3: every scan cycle moves the hand by exactly one slot, wrapping
    a_r3_hand_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |=> (hand_q == step($past(hand_q))));

    // R7: at the result the hand already rests after the victim
    a_r7_hand_rest: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid_o |-> (hand_q == step(victim_idx_o)));

    // R10: result is a single-cycle pulse
    a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid_o |=> !victim_valid_o);

    // R2: a result is always followed by idle, never a fresh scan
    a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid_o |=> !busy_o);

    // R2: the hand only moves while a search is running
    a_r2_hand_still: assert property (@(posedge clk) disable iff (!rst_n)
        !exam_en_o |=> $stable(hand_q));

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
    parameter int NUM_SLOTS = 8,
    parameter int CLEAN_N   = 1,
    parameter int DIRTY_N   = 2,
    parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_set_i,
    input  logic [IDX_W-1:0] ref_idx_i,
    input  logic             dirty_set_i,
    input  logic [IDX_W-1:0] dirty_idx_i,
    input  logic             fault_req_i,
    output logic             busy_o,
    output logic             victim_valid_o,
    output logic [IDX_W-1:0] victim_idx_o,
    output logic             victim_dirty_o
);

    localparam int CNT_W = $clog2(DIRTY_N + 1);

    logic             exam_en;
    logic [IDX_W-1:0] hand;
    logic             exam_victim;
    logic             exam_dirty;

    clock_slot_array #(
        .NUM_SLOTS (NUM_SLOTS),
        .CLEAN_N   (CLEAN_N),
        .DIRTY_N   (DIRTY_N),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W)
    ) u_slots (
        .clk           (clk),
        .rst_n         (rst_n),
        .ref_set_i     (ref_set_i),
        .ref_idx_i     (ref_idx_i),
        .dirty_set_i   (dirty_set_i),
        .dirty_idx_i   (dirty_idx_i),
        .exam_en_i     (exam_en),
        .exam_idx_i    (hand),
        .exam_victim_o (exam_victim),
        .exam_dirty_o  (exam_dirty)
    );

    clock_hand_fsm #(
        .NUM_SLOTS (NUM_SLOTS),
        .IDX_W     (IDX_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .fault_req_i    (fault_req_i),
        .exam_victim_i  (exam_victim),
        .exam_dirty_i   (exam_dirty),
        .exam_en_o      (exam_en),
        .hand_o         (hand),
        .busy_o         (busy_o),
        .victim_valid_o (victim_valid_o),
        .victim_idx_o   (victim_idx_o),
        .victim_dirty_o (victim_dirty_o)
    );

endmodule

// File: tb/tb_clock_victim_sel.sv
`timescale 1ns/1ps
module tb_clock_victim_sel;

    localparam int NS = 8;
    localparam int IW = $clog2(NS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_set = 1'b0;
    logic [IW-1:0] ref_idx = '0;
    logic          dirty_set = 1'b0;
    logic [IW-1:0] dirty_idx = '0;
    logic          fault_req = 1'b0;
    logic          busy;
    logic          vvalid;
    logic [IW-1:0] vidx;
    logic          vdirty;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    clock_victim_sel #(.NUM_SLOTS(NS), .CLEAN_N(1), .DIRTY_N(2)) dut (
        .clk(clk), .rst_n(rst_n),
        .ref_set_i(ref_set), .ref_idx_i(ref_idx),
        .dirty_set_i(dirty_set), .dirty_idx_i(dirty_idx),
        .fault_req_i(fault_req),
        .busy_o(busy), .victim_valid_o(vvalid),
        .victim_idx_o(vidx), .victim_dirty_o(vdirty)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<=100000", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic strobe_ref(input int idx);
        @(negedge clk);
        ref_set = 1'b1;
        ref_idx = IW'(idx);
        @(negedge clk);
        ref_set = 1'b0;
    endtask

    task automatic strobe_dirty(input int idx);
        @(negedge clk);
        dirty_set = 1'b1;
        dirty_idx = IW'(idx);
        @(negedge clk);
        dirty_set = 1'b0;
    endtask

    // raise a request; optional ref strobe (at wait step 1) and re-request (at step 2)
    task automatic fault(input int late_ref, input bit re_req,
                         output int idx, output int dty, output int lat);
        int n;
        @(negedge clk);
        fault_req = 1'b1;
        @(negedge clk);
        fault_req = 1'b0;
        n = 1;
        while (!vvalid && n < 60) begin
            if (n == 1 && late_ref >= 0) begin
                ref_set = 1'b1;
                ref_idx = IW'(late_ref);
            end
            if (n == 2 && re_req) fault_req = 1'b1;
            @(negedge clk);
            ref_set   = 1'b0;
            fault_req = 1'b0;
            n++;
        end
        idx = int'(vidx);
        dty = int'(vdirty);
        lat = n;
    endtask

    task automatic expect_victim(input string req, input int exp_idx, input int exp_d,
                                 input int exp_lat, input int late_ref, input bit re_req);
        int i, d, l;
        fault(late_ref, re_req, i, d, l);
        check(vvalid === 1'b1, req, int'(vvalid), 1);
        check(i == exp_idx, req, i, exp_idx);
        check(d == exp_d, req, d, exp_d);
        check(l == exp_lat, req, l, exp_lat);
        @(negedge clk);
        check(vvalid === 1'b0 && busy === 1'b0, "R10", int'(vvalid), 0);
    endtask

    task automatic t_reset;
        check(busy === 1'b0, "R1 busy", int'(busy), 0);
        check(vvalid === 1'b0, "R1 valid", int'(vvalid), 0);
        expect_victim("R1 first victim", 0, 0, 2, -1, 1'b0);
    endtask

    task automatic t_second_chance;
        strobe_ref(1);
        strobe_ref(2);
        expect_victim("R4 R5 skip referenced", 3, 0, 4, -1, 1'b0);
    endtask

    task automatic t_dirty_first_pass;
        strobe_dirty(4);
        check(vvalid === 1'b0 && busy === 1'b0, "R9 strobe no result", int'(busy), 0);
        expect_victim("R6 dirty survives once", 5, 0, 3, -1, 1'b0);
    endtask

    task automatic t_wrap_dirty_victim;
        for (int s = 6; s < 10; s++) strobe_ref(s % NS);
        strobe_ref(2);
        strobe_ref(3);
        expect_victim("R3 R6 wrap and dirty victim", 4, 1, 8, -1, 1'b0);
    endtask

    task automatic t_ref_during_scan;
        strobe_dirty(5);
        strobe_dirty(6);
        expect_victim("R9 ref during scan", 0, 0, 5, 7, 1'b0);
    endtask

    task automatic t_rest_and_clear;
        expect_victim("R7 hand rest", 1, 0, 2, -1, 1'b0);
        expect_victim("R7 hand rest", 2, 0, 2, -1, 1'b0);
        expect_victim("R7 hand rest", 3, 0, 2, -1, 1'b0);
        expect_victim("R8 victim cleared", 4, 0, 2, -1, 1'b0);
        expect_victim("R6 dirty second pass", 5, 1, 2, -1, 1'b0);
    endtask

    task automatic t_busy_drop;
        strobe_ref(6);
        strobe_ref(7);
        strobe_ref(0);
        expect_victim("R2 busy request", 1, 0, 5, -1, 1'b1);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(vvalid === 1'b0 && busy === 1'b0, "R2 dropped request",
                  int'(busy), 0);
        end
    endtask

    task automatic t_count_reset;
        for (int s = 2; s < 6; s++) strobe_ref(s);
        expect_victim("R4 count zeroed", 7, 0, 7, -1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_second_chance();
        t_dirty_first_pass();
        t_wrap_dirty_victim();
        t_ref_during_scan();
        t_rest_and_clear();
        t_busy_drop();
        t_count_reset();
        repeat (2) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule